// File: doc/BRIEF.md
# Voltage Sensor Setup and Channel Stepper

This block sits beside an on-chip multi-channel voltage sensor and handles the digital side of bringing it up. When the synchronous reset is released, it presents a fixed 12-bit setup word to the sensor and raises a configuration strobe for a fixed number of clock cycles. It then drops the strobe and stays in a running state until the next reset.

The setup word carries a 2-bit conversion-pattern field. When that field asks for channels chosen by user logic, the block also drives a 4-bit channel-select output. It walks that output through a parameterised list of up to eight channel numbers and moves to the next entry each time the sensor reports end of conversion. The list wraps after a programmable last slot. In the automatic patterns the sensor sequences channels on its own, so the channel-select output is held at zero.

Everything runs in one clock domain. There is no streamed data path: the end-of-conversion input is a plain pulse, the outputs are plain levels, and no valid/ready handshake or back-pressure is involved. The analog sensor and the capture of conversion results belong to other blocks.

Top module: `vsense_ctrl`

## Requirements
- R1: While `rst` is sampled high, `coreconfig` is 0 on the next cycle. `chsel` shows list slot 0 when the pattern field is 2'b11, and 0 otherwise.
- R2: On the first clock edge after `rst` goes low, `coreconfig` rises. It stays high for exactly `HOLD_CYCLES` cycles (default 4) and then stays low until the next reset.
- R3: `cfg_word` always equals the `CFG_WORD` parameter. Bits [1:0] are the pattern field: 00 = automatic over channels 2..7, 01 = automatic over channels 0..7, 11 = user-selected. Bit 2 sets the polarity of external channel 0 and bit 3 sets the polarity of external channel 1, where 1 means bipolar and 0 means unipolar.
- R4: When the pattern field is not 2'b11, `chsel` is 0 at all times.
- R5: In the running state with pattern 2'b11, every clock edge that samples `eoc` high moves `chsel` to the next list slot. The new value is visible after that edge. Slot k sits at bits [4k+3:4k] of `CH_LIST`.
- R6: After the slot numbered `LAST_IDX`, the next advance returns `chsel` to slot 0.
- R7: `chsel` changes only on an edge that samples `eoc` high while running. It therefore already holds its value for the whole strobe period, including the cycle before `coreconfig` falls, and in the cycle before `eoc` rises.
- R8: `eoc` pulses during reset or while `coreconfig` is high have no effect on `chsel`.
- R9: A reset taken while running returns `chsel` to slot 0, drops `coreconfig`, and starts a fresh configuration strobe once it is released.
- R10: If `eoc` is high on several consecutive edges, `chsel` advances once per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (single domain) |
| rst | input | 1 | Synchronous active-high reset |
| eoc | input | 1 | End-of-conversion pulse from the sensor |
| coreconfig | output | 1 | Configuration strobe to the sensor |
| cfg_word | output | 12 | Sensor setup word |
| chsel | output | 4 | Channel to convert next (user-selected pattern) |

## Verification
The hardest cases to reach from the ports are the ones where an end-of-conversion pulse arrives when it must be ignored, and the list wrap meeting a run of back-to-back pulses. The stimulus raises `eoc` during reset and across two edges of the configuration strobe, and checks that the first list entry survives until the strobe falls. It then mixes single pulses with a three-edge burst so that each of two instances, with last slots 3 and 7, wraps at least once. A reset in the middle of running then proves that the list restarts at slot 0.

// File: rtl/vsense_pkg.sv
`timescale 1ns/1ps
package vsense_pkg;

  localparam int CFG_W    = 12;
  localparam int MODE_LSB = 0;
  localparam int POL_LSB  = 2;

  typedef enum logic [1:0] {
    PAT_AUTO_UPPER = 2'b00,
    PAT_AUTO_ALL   = 2'b01,
    PAT_RESERVED   = 2'b10,
    PAT_USER       = 2'b11
  } vs_pattern_e;

  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_LOAD = 2'd1,
    VS_RUN  = 2'd2
  } vs_state_e;

  function automatic vs_pattern_e pattern_of(input logic [CFG_W-1:0] w);
    return vs_pattern_e'(w[MODE_LSB +: 2]);
  endfunction

endpackage

// File: rtl/vsense_cfg_fsm.sv
`timescale 1ns/1ps
module vsense_cfg_fsm
  import vsense_pkg::*;
#(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  output logic coreconfig,
  output logic running
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(HOLD_CYCLES - 1);

  vs_state_e      st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= VS_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        VS_IDLE: begin
          st  <= VS_LOAD;
          cnt <= '0;
        end
        VS_LOAD: begin
          if (cnt == LAST_CNT) st <= VS_RUN;
          else                 cnt <= cnt + 1'b1;
        end
        default: st <= VS_RUN;
      endcase
    end
  end

  assign coreconfig = (st == VS_LOAD);
  assign running    = (st == VS_RUN);
endmodule

// File: rtl/vsense_slot_ptr.sv
`timescale 1ns/1ps
module vsense_slot_ptr #(
  parameter int SLOTS    = 8,
  parameter int LAST_IDX = 3,
  parameter int PTR_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (ptr == LAST_P) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/vsense_chan_mux.sv
`timescale 1ns/1ps
module vsense_chan_mux #(
  parameter int                   SLOTS     = 8,
  parameter int                   CH_W      = 4,
  parameter int                   PTR_W     = 3,
  parameter logic [SLOTS*CH_W-1:0] CH_LIST  = '0,
  parameter bit                   USER_MODE = 1'b1
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [CH_W-1:0]  chsel
);
  logic [CH_W-1:0] tbl [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign tbl[k] = CH_LIST[k*CH_W +: CH_W];
  end

  assign chsel = USER_MODE ? tbl[ptr] : '0;
endmodule

// File: rtl/vsense_ctrl.sv
`timescale 1ns/1ps
module vsense_ctrl
  import vsense_pkg::*;
#(
  parameter logic [11:0] CFG_WORD    = 12'b0100_0100_0111,
  parameter int          HOLD_CYCLES = 4,
  parameter int          SLOTS       = 8,
  parameter int          CH_W        = 4,
  parameter int          LAST_IDX    = 3,
  parameter logic [SLOTS*CH_W-1:0] CH_LIST = 32'h0765_3124
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoc,
  output logic             coreconfig,
  output logic [CFG_W-1:0] cfg_word,
  output logic [CH_W-1:0]  chsel
);
  localparam int PTR_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam bit USER_MODE = (pattern_of(CFG_WORD) == PAT_USER);

  logic             running;
  logic [PTR_W-1:0] ptr;

  vsense_cfg_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .coreconfig(coreconfig), .running(running)
  );

  vsense_slot_ptr #(.SLOTS(SLOTS), .LAST_IDX(LAST_IDX), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .adv(running & eoc), .ptr(ptr)
  );

  vsense_chan_mux #(
    .SLOTS(SLOTS), .CH_W(CH_W), .PTR_W(PTR_W),
    .CH_LIST(CH_LIST), .USER_MODE(USER_MODE)
  ) u_mux (
    .ptr(ptr), .chsel(chsel)
  );

  assign cfg_word = CFG_WORD;
endmodule

// File: rtl/vsense_ctrl_chk.sv
`timescale 1ns/1ps
module vsense_ctrl_chk #(
  parameter int              HOLD_CYCLES = 4,
  parameter int              CH_W        = 4,
  parameter bit              USER_MODE   = 1'b1,
  parameter logic [CH_W-1:0] SLOT0       = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            eoc,
  input logic            coreconfig,
  input logic [CH_W-1:0] chsel
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYCLES);
  localparam logic [CH_W-1:0] IDLE_CH = USER_MODE ? SLOT0 : '0;

  logic          rst_q = 1'b0;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_state_R1: assert (coreconfig == 1'b0 && chsel == IDLE_CH)
        else $error("reset state wrong");
    end
    rst_q <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst)                               hi_cnt <= '0;
    else if (coreconfig && hi_cnt != HOLD_V) hi_cnt <= hi_cnt + 1'b1;
    else if (!coreconfig)                  hi_cnt <= '0;
  end

  assert_strobe_max_R2: assert property (@(posedge clk) disable iff (rst)
    coreconfig |-> (hi_cnt < HOLD_V));

  assert_strobe_len_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(coreconfig) && !$past(rst)) |-> (hi_cnt == HOLD_V));

  assert_hold_no_eoc_R7: assert property (@(posedge clk) disable iff (rst)
    !eoc |=> $stable(chsel));

  assert_ignore_in_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    coreconfig |=> $stable(chsel));

  if (!USER_MODE) begin : g_auto
    assert_auto_zero_R4: assert property (@(posedge clk) disable iff (rst)
      chsel == '0);
  end
endmodule

bind vsense_ctrl vsense_ctrl_chk #(
  .HOLD_CYCLES(HOLD_CYCLES), .CH_W(CH_W), .USER_MODE(USER_MODE),
  .SLOT0(CH_LIST[CH_W-1:0])
) u_chk (
  .clk(clk), .rst(rst), .eoc(eoc), .coreconfig(coreconfig), .chsel(chsel)
);

// File: tb/sim_vsense_ctrl.sv
`timescale 1ns/1ps
module sim_vsense_ctrl;
  logic clk = 1'b0, rst = 1'b1, eoc = 1'b0;
  always #4 clk = ~clk;

  logic        cc0, cc1, cc2;
  logic [11:0] w0, w1, w2;
  logic [3:0]  ch0, ch1, ch2;

  vsense_ctrl #(.CFG_WORD(12'b0100_0100_0111), .LAST_IDX(3)) u0 (
    .clk(clk), .rst(rst), .eoc(eoc), .coreconfig(cc0), .cfg_word(w0), .chsel(ch0));
  vsense_ctrl #(.CFG_WORD(12'b0100_0100_0001), .LAST_IDX(3)) u1 (
    .clk(clk), .rst(rst), .eoc(eoc), .coreconfig(cc1), .cfg_word(w1), .chsel(ch1));
  vsense_ctrl #(.CFG_WORD(12'b0000_0000_1111), .LAST_IDX(7)) u2 (
    .clk(clk), .rst(rst), .eoc(eoc), .coreconfig(cc2), .cfg_word(w2), .chsel(ch2));

  typedef struct { int val; string tag; } exp_t;
  exp_t q0[$];
  exp_t q2[$];
  int total = 0, bad = 0;
  bit done = 1'b0;
  int lst [8] = '{4, 2, 1, 3, 5, 6, 7, 0};
  int p0 = 0, p2 = 0;

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver side: advance the reference pointers and queue expected channels
  task automatic push_step(string tag);
    exp_t e;
    p0 = (p0 == 3) ? 0 : p0 + 1;
    p2 = (p2 == 7) ? 0 : p2 + 1;
    e.tag = tag; e.val = lst[p0]; q0.push_back(e);
    e.val = lst[p2]; q2.push_back(e);
  endtask

  task automatic pulse(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      eoc = 1'b1;
      push_step(tag);
    end
    @(negedge clk);
    eoc = 1'b0;
  endtask

  // monitor: compare after each edge that consumed a queued step
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q0.size() > 0) begin
        exp_t e;
        e = q0.pop_front();
        chk({e.tag, " u0"}, int'(ch0), e.val);
        e = q2.pop_front();
        chk({e.tag, " u2"}, int'(ch2), e.val);
        chk("R4 u1", int'(ch1), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 u0 coreconfig", int'(cc0), 0);
    chk("R1 u0 chsel", int'(ch0), 4);
    chk("R1 u1 chsel", int'(ch1), 0);
    chk("R1 u2 chsel", int'(ch2), 4);
    chk("R3 u0 word", int'(w0), 12'h447);
    chk("R3 u1 word", int'(w1), 12'h441);
    chk("R3 u2 word", int'(w2), 12'h00F);

    eoc = 1'b1;                        // R8: pulse while in reset
    @(negedge clk);
    eoc = 1'b0;
    @(negedge clk);
    chk("R8 reset eoc", int'(ch0), 4);

    rst = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R2 u0 strobe", int'(cc0), (k <= 4) ? 1 : 0);
      chk("R2 u1 strobe", int'(cc1), (k <= 4) ? 1 : 0);
      chk("R7 u0 ready during strobe", int'(ch0), 4);
      if (k == 2) eoc = 1'b1;          // R8: pulse across two strobe edges
      if (k == 4) eoc = 1'b0;
    end
    chk("R8 u2 strobe eoc", int'(ch2), 4);
    repeat (3) begin
      @(negedge clk);
      chk("R2 strobe stays low", int'(cc0), 0);
    end

    pulse(1, "R5"); pulse(1, "R5"); pulse(1, "R5");
    pulse(1, "R6");                    // u0 wraps after slot 3
    repeat (3) @(negedge clk);
    chk("R7 hold between eoc", int'(ch0), lst[p0]);
    chk("R7 hold u2", int'(ch2), lst[p2]);

    pulse(3, "R10");                   // back-to-back eoc
    pulse(1, "R6");                    // u2 wraps after slot 7
    pulse(2, "R5");
    chk("R4 u1 after run", int'(ch1), 0);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 u0 chsel", int'(ch0), 4);
    chk("R9 u2 chsel", int'(ch2), 4);
    chk("R9 coreconfig low", int'(cc0), 0);
    rst = 1'b0;
    p0 = 0; p2 = 0;
    @(negedge clk);
    chk("R9 strobe restarts", int'(cc0), 1);
    repeat (4) @(negedge clk);
    chk("R9 strobe ends", int'(cc0), 0);
    pulse(1, "R9");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule